// File: doc/BRIEF.md
# Ultra DMA Transfer Control and Status Unit

This unit sits between a host's register bus and the data path of an Ultra DMA transfer on an ATA host. Software programs a direction and then arms the engine with a fixed three-step sequence. Once armed, the engine moves 32-bit words through a one-word buffer between the system DMA side and the device side, and it counts each word that crosses the device side. The expected length comes from a side input. A simple strobe and stop handshake takes the place of the real cable protocol.

When the device ends a burst early, the unit records which direction was left unfinished. It also flags a transfer whose word count is not a multiple of four, and it raises an error interrupt for either case. A two-bit classification output folds the error flags, the device interrupt line and the busy state into one priority-encoded verdict. Software can then decide with a single look whether the transfer failed, was interrupted, is still running, or is done.

Top module: `udma_ctl_unit`

## Requirements
- R1: The operation register sits at word address 0 and the status register at word address 1. In the operation register, bit 0 is the enable bit and bit 1 is the direction bit (1 = toward the device). A write of the direction is read back unchanged in bit 1.
- R2: The engine starts only after three accesses: a write to the operation register with the enable bit clear, then a read of the operation register, then a write with the enable bit set. A write with the enable bit set that does not directly follow such a read leaves the engine idle.
- R3: Status bit positions are: 16 DMA request, 17 error interrupt, 18 busy, 24 toward-device incomplete, 25 from-device incomplete, 26 count not a multiple of four. All other bits read 0, and after reset the whole status word is 0.
- R4: Each word passes through the buffer unchanged in both directions. Busy clears on its own once the device-side word count equals the programmed length and the buffer is empty.
- R5: While busy, the DMA request is high for a toward-device transfer when the buffer is empty, and for a from-device transfer when the buffer is full.
- R6: A device stop while the transfer is incomplete ends the transfer. It sets the toward-device incomplete flag for the toward-device direction, and the from-device incomplete flag for the other direction.
- R7: At the end of a transfer, whether early or complete, the not-multiple-of-four flag is set when the number of words moved modulo 4 is nonzero.
- R8: The error interrupt status bit and the irq output rise together with any error flag.
- R9: A write to the operation register with the enable bit clear stops the engine: busy and DMA request go low. It also clears every error flag and the error interrupt.
- R10: The class output encodes 3 = error (any error flag or the error interrupt), else 2 = device interrupt input high, else 1 = busy or DMA request, else 0 = idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | BUS_W | Write data |
| bus_rdata | output | BUS_W | Read data, valid in the access cycle |
| xfer_len | input | LEN_W | Transfer length in words, sampled at arming |
| dev_intrq | input | 1 | Device interrupt line |
| dma_req | output | 1 | Word request to the system DMA side |
| dma_ack | input | 1 | System DMA moves one word this cycle |
| dma_wdata | input | DATA_W | Word from memory (toward device) |
| dma_rdata | output | DATA_W | Word to memory (from device) |
| dev_strobe | input | 1 | Device moves one word this cycle |
| dev_stop | input | 1 | Device ends the burst |
| dev_wdata | input | DATA_W | Word from the device |
| dev_rdata | output | DATA_W | Word to the device |
| irq | output | 1 | Error interrupt |
| xfer_class | output | 2 | Priority-encoded transfer verdict |

## Verification
Full transfers are run in both directions with distinct word values. These show that data passes through the buffer unchanged and that the request polarity flips with the direction. Early stops use three and then four words moved. This separates the direction-specific incomplete flags from the multiple-of-four flag. A complete transfer of six words shows that the multiple-of-four flag also fires without an early stop.

Enabling without the intervening read, stopping mid-transfer, and driving the device interrupt line with and without pending errors exercise the arming order, the halt path and each level of the class priority.

// File: rtl/udma_ctl_pkg.sv
package udma_ctl_pkg;
   localparam int OP_UEN_BIT  = 0;
   localparam int OP_DIR_BIT  = 1;
   localparam int ST_DREQ_BIT = 16;
   localparam int ST_EINT_BIT = 17;
   localparam int ST_BUSY_BIT = 18;
   localparam int ST_NDO_BIT  = 24;
   localparam int ST_NDI_BIT  = 25;
   localparam int ST_N4X_BIT  = 26;

   typedef enum logic [1:0] {
      ARM_IDLE      = 2'd0,
      ARM_DIR_SET   = 2'd1,
      ARM_READ_SEEN = 2'd2
   } arm_state_t;

   typedef enum logic [1:0] {
      CLS_IDLE   = 2'b00,
      CLS_ACTIVE = 2'b01,
      CLS_INTR   = 2'b10,
      CLS_ERROR  = 2'b11
   } xfer_class_t;

   typedef struct packed {
      logic n4x;
      logic ndi;
      logic ndo;
   } err_flags_t;
endpackage

// File: rtl/udma_arm_seq.sv
module udma_arm_seq
   import udma_ctl_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic op_wr,
   input  logic op_rd,
   input  logic uen_bit,
   input  logic dir_bit,
   output logic start,
   output logic halt,
   output logic dir_q,
   output logic uen_q
);
   arm_state_t state_q;

   assign halt  = op_wr & ~uen_bit;
   assign start = op_wr & uen_bit & (state_q == ARM_READ_SEEN);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ARM_IDLE;
         dir_q   <= 1'b0;
         uen_q   <= 1'b0;
      end else if (halt) begin
         state_q <= ARM_DIR_SET;
         dir_q   <= dir_bit;
         uen_q   <= 1'b0;
      end else if (op_wr) begin
         state_q <= ARM_IDLE;
         if (start) begin
            uen_q <= 1'b1;
            dir_q <= dir_bit;
         end
      end else if (op_rd && state_q == ARM_DIR_SET) begin
         state_q <= ARM_READ_SEEN;
      end
   end

   // R2: an enable only takes effect from the read-seen step
   a_r2_start_from_read: assert property (@(posedge clk) disable iff (!rst_n)
      (op_wr && uen_bit && state_q != ARM_READ_SEEN) |=> !uen_q || $past(uen_q));
endmodule

// File: rtl/udma_word_track.sv
module udma_word_track #(
   parameter int DATA_W = 32,
   parameter int LEN_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              halt,
   input  logic              dir_in,
   input  logic [LEN_W-1:0]  len_in,
   input  logic              dma_ack,
   input  logic [DATA_W-1:0] dma_wdata,
   input  logic              dev_strobe,
   input  logic              dev_stop,
   input  logic [DATA_W-1:0] dev_wdata,
   output logic              busy,
   output logic              dma_req,
   output logic [DATA_W-1:0] dma_rdata,
   output logic [DATA_W-1:0] dev_rdata,
   output logic              end_early,
   output logic              end_done,
   output logic              end_dir,
   output logic [1:0]        cnt_lo2
);
   logic              busy_q, dir_q, full_q;
   logic [LEN_W-1:0]  len_q, cnt_q;
   logic [DATA_W-1:0] buf_q;
   logic              done_now, live, fill, drain, count_up;

   assign done_now = busy_q & (cnt_q == len_q) & ~full_q;
   assign live     = busy_q & ~done_now & ~dev_stop & ~halt & ~start;
   assign dma_req  = busy_q & ~done_now & (dir_q ? ~full_q : full_q);

   always_comb begin
      if (dir_q) begin
         fill     = live & ~full_q & dma_ack;
         drain    = live &  full_q & dev_strobe;
         count_up = drain;
      end else begin
         fill     = live & ~full_q & dev_strobe;
         drain    = live &  full_q & dma_ack;
         count_up = fill;
      end
   end

   assign end_early = busy_q & dev_stop & ~done_now & ~halt & ~start;
   assign end_done  = done_now & ~halt & ~start;
   assign end_dir   = dir_q;
   assign cnt_lo2   = cnt_q[1:0];
   assign busy      = busy_q;
   assign dma_rdata = buf_q;
   assign dev_rdata = buf_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         dir_q  <= 1'b0;
         full_q <= 1'b0;
         len_q  <= '0;
         cnt_q  <= '0;
         buf_q  <= '0;
      end else if (halt) begin
         busy_q <= 1'b0;
         full_q <= 1'b0;
      end else if (start) begin
         busy_q <= 1'b1;
         dir_q  <= dir_in;
         len_q  <= len_in;
         cnt_q  <= '0;
         full_q <= 1'b0;
      end else if (end_early || end_done) begin
         busy_q <= 1'b0;
         full_q <= 1'b0;
      end else begin
         if (fill) begin
            full_q <= 1'b1;
            buf_q  <= dir_q ? dma_wdata : dev_wdata;
         end else if (drain) begin
            full_q <= 1'b0;
         end
         if (count_up) cnt_q <= cnt_q + 1'b1;
      end
   end

   // R4: the word count never runs past the programmed length
   a_r4_cnt_within_len: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> cnt_q <= len_q);
   // R5: an accepted toward-device word fills the buffer
   a_r5_out_fill: assert property (@(posedge clk) disable iff (!rst_n)
      (dir_q && dma_req && dma_ack && live) |=> full_q);
endmodule

// File: rtl/udma_err_flags.sv
module udma_err_flags
   import udma_ctl_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       clear,
   input  logic       end_early,
   input  logic       end_done,
   input  logic       end_dir,
   input  logic [1:0] cnt_lo2,
   output err_flags_t flags,
   output logic       eint
);
   logic odd_len;
   assign odd_len = (cnt_lo2 != 2'b00);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags <= '0;
         eint  <= 1'b0;
      end else if (clear) begin
         flags <= '0;
         eint  <= 1'b0;
      end else if (end_early) begin
         flags.ndo <= flags.ndo |  end_dir;
         flags.ndi <= flags.ndi | ~end_dir;
         flags.n4x <= flags.n4x | odd_len;
         eint      <= 1'b1;
      end else if (end_done && odd_len) begin
         flags.n4x <= 1'b1;
         eint      <= 1'b1;
      end
   end

   // R8: a raised error flag always comes with the error interrupt
   a_r8_eint_tracks_flags: assert property (@(posedge clk) disable iff (!rst_n)
      (|flags) |-> eint);
endmodule

// File: rtl/udma_ctl_unit.sv
module udma_ctl_unit
   import udma_ctl_pkg::*;
#(
   parameter int ADDR_W = 4,
   parameter int BUS_W  = 32,
   parameter int DATA_W = 32,
   parameter int LEN_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   input  logic [LEN_W-1:0]  xfer_len,
   input  logic              dev_intrq,
   output logic              dma_req,
   input  logic              dma_ack,
   input  logic [DATA_W-1:0] dma_wdata,
   output logic [DATA_W-1:0] dma_rdata,
   input  logic              dev_strobe,
   input  logic              dev_stop,
   input  logic [DATA_W-1:0] dev_wdata,
   output logic [DATA_W-1:0] dev_rdata,
   output logic              irq,
   output logic [1:0]        xfer_class
);
   localparam logic [ADDR_W-1:0] OP_ADDR = '0;
   localparam logic [ADDR_W-1:0] ST_ADDR = ADDR_W'(1);

   generate
      if (BUS_W < ST_N4X_BIT + 1) begin : g_bus_too_narrow
         $error("BUS_W must hold the highest status bit");
      end
      if (LEN_W < 2) begin : g_len_too_narrow
         $error("LEN_W must be at least 2");
      end
      if (ADDR_W < 1) begin : g_addr_too_narrow
         $error("ADDR_W must be at least 1");
      end
   endgenerate

   logic op_hit, st_hit, op_wr, op_rd;
   logic start, halt, dir_q, uen_q;
   logic busy, end_early, end_done, end_dir;
   logic [1:0] cnt_lo2;
   err_flags_t flags;
   logic eint;
   xfer_class_t cls;
   logic unused_wdata_bits;

   assign op_hit = bus_sel & (bus_addr == OP_ADDR);
   assign st_hit = bus_sel & (bus_addr == ST_ADDR);
   assign op_wr  = op_hit &  bus_wr;
   assign op_rd  = op_hit & ~bus_wr;
   assign unused_wdata_bits = ^bus_wdata[BUS_W-1:2];

   udma_arm_seq u_arm (
      .clk     (clk),
      .rst_n   (rst_n),
      .op_wr   (op_wr),
      .op_rd   (op_rd),
      .uen_bit (bus_wdata[OP_UEN_BIT]),
      .dir_bit (bus_wdata[OP_DIR_BIT]),
      .start   (start),
      .halt    (halt),
      .dir_q   (dir_q),
      .uen_q   (uen_q)
   );

   udma_word_track #(.DATA_W(DATA_W), .LEN_W(LEN_W)) u_track (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .halt       (halt),
      .dir_in     (bus_wdata[OP_DIR_BIT]),
      .len_in     (xfer_len),
      .dma_ack    (dma_ack),
      .dma_wdata  (dma_wdata),
      .dev_strobe (dev_strobe),
      .dev_stop   (dev_stop),
      .dev_wdata  (dev_wdata),
      .busy       (busy),
      .dma_req    (dma_req),
      .dma_rdata  (dma_rdata),
      .dev_rdata  (dev_rdata),
      .end_early  (end_early),
      .end_done   (end_done),
      .end_dir    (end_dir),
      .cnt_lo2    (cnt_lo2)
   );

   udma_err_flags u_err (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (halt),
      .end_early (end_early),
      .end_done  (end_done),
      .end_dir   (end_dir),
      .cnt_lo2   (cnt_lo2),
      .flags     (flags),
      .eint      (eint)
   );

   always_comb begin
      bus_rdata = '0;
      if (op_hit && !bus_wr) begin
         bus_rdata[OP_UEN_BIT] = uen_q;
         bus_rdata[OP_DIR_BIT] = dir_q;
      end else if (st_hit && !bus_wr) begin
         bus_rdata[ST_DREQ_BIT] = dma_req;
         bus_rdata[ST_EINT_BIT] = eint;
         bus_rdata[ST_BUSY_BIT] = busy;
         bus_rdata[ST_NDO_BIT]  = flags.ndo;
         bus_rdata[ST_NDI_BIT]  = flags.ndi;
         bus_rdata[ST_N4X_BIT]  = flags.n4x;
      end
   end

   always_comb begin
      if ((|flags) || eint)      cls = CLS_ERROR;
      else if (dev_intrq)        cls = CLS_INTR;
      else if (busy || dma_req)  cls = CLS_ACTIVE;
      else                       cls = CLS_IDLE;
   end

   assign xfer_class = cls;
   assign irq        = eint;

   // R2: busy only rises on the cycle after an enable write
   a_r2_busy_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(op_wr && bus_wdata[OP_UEN_BIT]));
   // R6: incomplete flags only appear out of a running transfer
   a_r6_ndx_from_busy: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(flags.ndo) || $rose(flags.ndi)) |-> $past(busy));
   // R9: an enable-clear write idles the engine and clears the interrupt
   a_r9_halt_idles: assert property (@(posedge clk) disable iff (!rst_n)
      (op_wr && !bus_wdata[OP_UEN_BIT]) |=> (!busy && !dma_req && !irq));
endmodule

// File: tb/sim_udma_ctl_unit.sv
`timescale 1ns/1ps
module sim_udma_ctl_unit;
   localparam int ADDR_W = 4;
   localparam int BUS_W  = 32;
   localparam int DATA_W = 32;
   localparam int LEN_W  = 16;

   localparam logic [31:0] S_DREQ = 32'h0001_0000;
   localparam logic [31:0] S_EINT = 32'h0002_0000;
   localparam logic [31:0] S_BUSY = 32'h0004_0000;
   localparam logic [31:0] S_NDO  = 32'h0100_0000;
   localparam logic [31:0] S_NDI  = 32'h0200_0000;
   localparam logic [31:0] S_N4X  = 32'h0400_0000;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bus_sel = 1'b0, bus_wr = 1'b0;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic [BUS_W-1:0]  bus_wdata = '0;
   logic [BUS_W-1:0]  bus_rdata;
   logic [LEN_W-1:0]  xfer_len = '0;
   logic dev_intrq = 1'b0, dma_req, dma_ack = 1'b0;
   logic [DATA_W-1:0] dma_wdata = '0, dma_rdata, dev_wdata = '0, dev_rdata;
   logic dev_strobe = 1'b0, dev_stop = 1'b0, irq;
   logic [1:0] xfer_class;

   int n_checks = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   udma_ctl_unit #(.ADDR_W(ADDR_W), .BUS_W(BUS_W), .DATA_W(DATA_W), .LEN_W(LEN_W)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .xfer_len(xfer_len), .dev_intrq(dev_intrq),
      .dma_req(dma_req), .dma_ack(dma_ack), .dma_wdata(dma_wdata), .dma_rdata(dma_rdata),
      .dev_strobe(dev_strobe), .dev_stop(dev_stop), .dev_wdata(dev_wdata), .dev_rdata(dev_rdata),
      .irq(irq), .xfer_class(xfer_class));

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
   endtask

   task automatic bus_read(input logic [ADDR_W-1:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   task automatic arm(input logic dir, input int len);
      logic [31:0] tmp;
      xfer_len = LEN_W'(len);
      bus_write(0, {30'd0, dir, 1'b0});
      bus_read(0, tmp);
      bus_write(0, {30'd0, dir, 1'b1});
   endtask

   // one toward-device word; call at a negedge with dma_req high
   task automatic move_out(input logic [31:0] w);
      chk("R5 out req when empty", {31'd0, dma_req}, 32'd1);
      dma_ack = 1'b1; dma_wdata = w;
      @(negedge clk);
      dma_ack = 1'b0;
      chk("R5 out req low when full", {31'd0, dma_req}, 32'd0);
      chk("R4 out data", dev_rdata, w);
      dev_strobe = 1'b1;
      @(negedge clk);
      dev_strobe = 1'b0;
   endtask

   task automatic move_in(input logic [31:0] w);
      chk("R5 in req low when empty", {31'd0, dma_req}, 32'd0);
      dev_strobe = 1'b1; dev_wdata = w;
      @(negedge clk);
      dev_strobe = 1'b0;
      chk("R5 in req when full", {31'd0, dma_req}, 32'd1);
      chk("R4 in data", dma_rdata, w);
      dma_ack = 1'b1;
      @(negedge clk);
      dma_ack = 1'b0;
   endtask

   task automatic status(output logic [31:0] s);
      bus_read(1, s);
   endtask

   task automatic t_reset;
      logic [31:0] s;
      status(s);
      chk("R3 reset status", s, 32'd0);
      chk("R10 reset class", {30'd0, xfer_class}, 32'd0);
      chk("R8 reset irq", {31'd0, irq}, 32'd0);
   endtask

   task automatic t_op_readback;
      logic [31:0] s;
      bus_write(0, 32'd2);
      bus_read(0, s);
      chk("R1 op readback", s, 32'd2);
   endtask

   task automatic t_skip_read;
      logic [31:0] s;
      xfer_len = 16'd4;
      bus_write(0, 32'd2);
      bus_write(0, 32'd3);
      status(s);
      chk("R2 enable without read stays idle", s, 32'd0);
      chk("R2 no request", {31'd0, dma_req}, 32'd0);
   endtask

   task automatic t_out_full;
      logic [31:0] s;
      arm(1'b1, 8);
      status(s);
      chk("R3 busy and request bits", s, S_BUSY | S_DREQ);
      chk("R10 active class", {30'd0, xfer_class}, 32'd1);
      for (int i = 0; i < 8; i++) move_out(32'hA5A5_0000 + 32'(i * 17));
      @(negedge clk);
      status(s);
      chk("R4 out complete idle", s, 32'd0);
      chk("R10 idle class", {30'd0, xfer_class}, 32'd0);
   endtask

   task automatic t_in_full;
      logic [31:0] s;
      arm(1'b0, 4);
      status(s);
      chk("R5 in armed, no request", s, S_BUSY);
      dev_intrq = 1'b1;
      #1 chk("R10 intr over active", {30'd0, xfer_class}, 32'd2);
      dev_intrq = 1'b0;
      for (int i = 0; i < 4; i++) move_in(32'h1234_5600 ^ 32'(i << 20));
      @(negedge clk);
      status(s);
      chk("R4 in complete idle", s, 32'd0);
   endtask

   task automatic t_in_stop;
      logic [31:0] s;
      arm(1'b0, 8);
      for (int i = 0; i < 3; i++) move_in(32'(i + 1));
      dev_stop = 1'b1;
      @(negedge clk);
      dev_stop = 1'b0;
      status(s);
      chk("R6 R7 in early stop flags", s, S_NDI | S_N4X | S_EINT);
      chk("R8 irq raised", {31'd0, irq}, 32'd1);
      chk("R10 error class", {30'd0, xfer_class}, 32'd3);
      dev_intrq = 1'b1;
      #1 chk("R10 error beats intr", {30'd0, xfer_class}, 32'd3);
      dev_intrq = 1'b0;
   endtask

   task automatic t_clear;
      logic [31:0] s;
      bus_write(0, 32'd0);
      status(s);
      chk("R9 flags cleared", s, 32'd0);
      chk("R9 irq cleared", {31'd0, irq}, 32'd0);
   endtask

   task automatic t_out_stop;
      logic [31:0] s;
      arm(1'b1, 8);
      for (int i = 0; i < 4; i++) move_out(32'hF0F0_0000 | 32'(i));
      dev_stop = 1'b1;
      @(negedge clk);
      dev_stop = 1'b0;
      status(s);
      chk("R6 out early stop no N4X R7", s, S_NDO | S_EINT);
      bus_write(0, 32'd0);
   endtask

   task automatic t_len6;
      logic [31:0] s;
      arm(1'b1, 6);
      for (int i = 0; i < 6; i++) move_out(32'(i * 3));
      @(negedge clk);
      status(s);
      chk("R7 six words complete", s, S_N4X | S_EINT);
      bus_write(0, 32'd0);
   endtask

   task automatic t_halt;
      logic [31:0] s;
      arm(1'b0, 8);
      move_in(32'hDEAD_BEEF);
      bus_write(0, 32'd0);
      status(s);
      chk("R9 halt mid transfer", s, 32'd0);
      chk("R9 halt request low", {31'd0, dma_req}, 32'd0);
      dev_intrq = 1'b1;
      #1 chk("R10 intr when idle", {30'd0, xfer_class}, 32'd2);
      dev_intrq = 1'b0;
   endtask

   initial begin
      #(200000 * 5);
      if (!finished) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_op_readback();
      t_skip_read();
      t_out_full();
      t_in_full();
      t_in_stop();
      t_clear();
      t_out_stop();
      t_len6();
      t_halt();
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end
endmodule